// File: doc/BRIEF.md
# Multi-channel PRBS bit-error-rate checker

This block measures the bit error rate of many parallel links at once. A frame strobe marks the arrival, once per slow frame period, of a 10-bit frame on every channel. After a start command each channel captures its first frame as the seed of its own pseudo-random reference (PRBS-7, polynomial x^7 + x^6 + 1). From the next frame on, it predicts every frame, compares all ten bits and adds the number of wrong bits to a saturating error counter for that channel. One shared counter holds the number of bits checked per channel, so the error rate of channel c is its error count divided by that bit count.

The same sequence generator also drives a generator output. Each frame strobe moves it on by one frame, so a loopback path or a far-end transmitter can be fed with data that the checker accepts. Counting runs only between start and stop. Clear zeroes every counter and drops the lock. A register read port with one cycle of latency returns the bit count and the per-channel error counts.

Top module: `prbs_err_checker`

## Requirements
- R1: The sequence is PRBS-7 with the new bit equal to state[6] XOR state[5], shifted into state[0]. Within a frame, bit 0 is the oldest bit. The generator starts from state 7'h7F and holds frame 0 after reset. On each cycle with `frame_vld` high it emits the next 10 sequence bits on `gen_frame`, visible after that clock edge.
- R2: The first accepted frame after start loads each channel's reference from that frame and raises `synced`, with no count. Bit k of the reference state is frame bit 9-k.
- R3: Each later accepted frame is compared with the predicted frame, and each channel's error count grows by the number of differing bits.
- R4: The shared bit count grows by 10 for each compared frame.
- R5: An error count that would pass 2^ERR_W-1 stays at 2^ERR_W-1.
- R6: A channel's `lost` flag is set when all 10 bits of a compared frame differ. It stays set until clear.
- R7: Clear zeroes all counters, `lost` flags and `synced`, leaves `running` as it was, and wins over a frame in the same cycle.
- R8: A frame is accepted only when `running` is high and start, stop and clear are all low in that cycle. Start sets `running` and drops `synced`. Stop clears `running` and wins over start.
- R9: Reading address 0 returns bit count [31:0], address 1 returns bit count bits 32 and up, and address 2+c returns the error count of channel c, zero-extended. All other addresses return 0. `rd_data` follows `rd_addr` by one clock.
- R10: After reset all counters read 0, `running`, `synced` and `lost` are 0, and `gen_frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One-cycle strobe: new frame on all channels |
| rx_frames | input | NCH*10 | Received frames, channel c at bits [10c+9:10c] |
| start | input | 1 | Start a run and resynchronise |
| stop | input | 1 | End the run |
| clear | input | 1 | Zero counters, flags and lock |
| rd_addr | input | $clog2(NCH+2) | Register read address |
| rd_data | output | 32 | Read data, one cycle after address |
| gen_frame | output | 10 | Generated pseudo-random frame |
| running | output | 1 | Run in progress |
| synced | output | 1 | References loaded |
| lost | output | NCH | Per-channel all-bits-wrong flag |

## Verification
A frame strobe can fall in the same cycle as clear, start or stop. The block's acceptance and clearing logic must then pick one outcome. The bench drives the strobe together with clear while counts are non-zero. It expects all counters and `synced` to be zero, and the next frame to act only as a sync frame. It also pairs the strobe with start and expects no count and no lock. It then pairs start with stop and expects `running` to stay low.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int FRAME_W = 10;
    localparam int LFSR_W  = 7;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LFSR_W-1:0]  state;
    } prbs_step_t;

    // Run the x^7+x^6+1 register for one frame; bit 0 is produced first.
    function automatic prbs_step_t prbs_advance(input logic [LFSR_W-1:0] s);
        prbs_step_t r;
        logic [LFSR_W-1:0] st;
        logic nb;
        st = s;
        r.bits = '0;
        for (int i = 0; i < FRAME_W; i++) begin
            nb = st[6] ^ st[5];
            r.bits[i] = nb;
            st = {st[5:0], nb};
        end
        r.state = st;
        return r;
    endfunction

    // The last seven bits of a frame are the register contents after it.
    function automatic logic [LFSR_W-1:0] prbs_seed_from(input logic [FRAME_W-1:0] f);
        logic [LFSR_W-1:0] s;
        for (int k = 0; k < LFSR_W; k++) begin
            s[k] = f[FRAME_W-1-k];
        end
        return s;
    endfunction

    function automatic logic [3:0] ones_in_frame(input logic [FRAME_W-1:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < FRAME_W; i++) begin
            n = n + 4'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    output logic [FRAME_W-1:0] frame
);

    typedef struct packed {
        logic [LFSR_W-1:0]  lfsr;
        logic [FRAME_W-1:0] frame;
    } gen_st_t;

    gen_st_t    d, q;
    prbs_step_t step;

    always_comb begin
        d    = q;
        step = prbs_advance(q.lfsr);
        if (adv) begin
            d.lfsr  = step.state;
            d.frame = step.bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.lfsr  <= '1;
            q.frame <= '0;
        end else begin
            q <= d;
        end
    end

    assign frame = q.frame;

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q.lfsr != '0);                                                   // R1
    AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q.frame));                                      // R1

endmodule

// File: rtl/prbs_ctrl.sv
module prbs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_vld,
    input  logic start,
    input  logic stop,
    input  logic clear,
    output logic running,
    output logic synced,
    output logic load,
    output logic cmp
);

    typedef struct packed {
        logic run;
        logic sync;
    } ctrl_st_t;

    ctrl_st_t d, q;
    logic     accept;

    always_comb begin
        d      = q;
        accept = frame_vld & q.run & ~start & ~stop & ~clear;
        load   = accept & ~q.sync;
        cmp    = accept &  q.sync;
        if (stop) begin
            d.run = 1'b0;
        end else if (start) begin
            d.run = 1'b1;
        end
        if (clear || start) begin
            d.sync = 1'b0;
        end else if (load) begin
            d.sync = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign running = q.run;
    assign synced  = q.sync;

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !running);                                              // R8
    AST_START_DESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !synced);                                              // R2
    AST_CLEAR_DESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !synced);                                              // R7

endmodule

// File: rtl/prbs_lane.sv
module prbs_lane
    import prbs_pkg::*;
#(
    parameter int ERR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               load,
    input  logic               cmp,
    input  logic [FRAME_W-1:0] rx,
    output logic [ERR_W-1:0]   err_cnt,
    output logic               lost
);

    typedef struct packed {
        logic [LFSR_W-1:0] ref_st;
        logic [ERR_W-1:0]  err;
        logic              lost;
    } lane_st_t;

    lane_st_t     d, q;
    prbs_step_t   step;
    logic [3:0]   miss;
    logic [ERR_W:0] sum;

    always_comb begin
        d    = q;
        step = prbs_advance(q.ref_st);
        miss = ones_in_frame(step.bits ^ rx);
        sum  = {1'b0, q.err} + (ERR_W+1)'(miss);
        if (clr) begin
            d.err  = '0;
            d.lost = 1'b0;
        end else if (load) begin
            d.ref_st = prbs_seed_from(rx);
        end else if (cmp) begin
            d.ref_st = step.state;
            d.err    = sum[ERR_W] ? '1 : sum[ERR_W-1:0];
            if (miss == 4'(FRAME_W)) begin
                d.lost = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign err_cnt = q.err;
    assign lost    = q.lost;

    AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> q.err >= $past(q.err));                                 // R5
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp && !clr) |=> $stable(q.err));                              // R3
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lost && !clr) |=> q.lost);                                    // R6
    AST_LANE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.err == '0 && !q.lost));                               // R7

endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
    import prbs_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int ERR_W = 32,
    parameter int BIT_W = 48,
    localparam int NREG = NCH + 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_vld,
    input  logic [NCH*FRAME_W-1:0] rx_frames,
    input  logic                   start,
    input  logic                   stop,
    input  logic                   clear,
    input  logic [AW-1:0]          rd_addr,
    output logic [31:0]            rd_data,
    output logic [FRAME_W-1:0]     gen_frame,
    output logic                   running,
    output logic                   synced,
    output logic [NCH-1:0]         lost
);

    typedef struct packed {
        logic [BIT_W-1:0] bits;
        logic [31:0]      rd;
    } top_st_t;

    top_st_t          d, q;
    logic             load, cmp;
    logic [ERR_W-1:0] err_arr [NCH];

    prbs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .start     (start),
        .stop      (stop),
        .clear     (clear),
        .running   (running),
        .synced    (synced),
        .load      (load),
        .cmp       (cmp)
    );

    prbs_gen u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (frame_vld),
        .frame (gen_frame)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        prbs_lane #(.ERR_W(ERR_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clear),
            .load    (load),
            .cmp     (cmp),
            .rx      (rx_frames[c*FRAME_W +: FRAME_W]),
            .err_cnt (err_arr[c]),
            .lost    (lost[c])
        );
    end

    always_comb begin
        d = q;
        if (clear) begin
            d.bits = '0;
        end else if (cmp) begin
            d.bits = q.bits + BIT_W'(FRAME_W);
        end
        d.rd = '0;
        if (rd_addr == AW'(0)) begin
            d.rd = q.bits[31:0];
        end else if (rd_addr == AW'(1)) begin
            d.rd = 32'(q.bits >> 32);
        end
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == AW'(c + 2)) begin
                d.rd = 32'(err_arr[c]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.rd;

    AST_BITS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (q.bits == $past(q.bits) ||
                    q.bits == $past(q.bits) + BIT_W'(FRAME_W)));         // R4
    AST_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> q.bits == '0);                                         // R7
    AST_BITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clear) |=> $stable(q.bits));                       // R8

endmodule

// File: tb/tb_prbs_err_checker.sv
`timescale 1ns/1ps
module tb_prbs_err_checker;

    localparam int NCH   = 4;
    localparam int ERR_W = 6;
    localparam int EMAX  = (1 << ERR_W) - 1;
    localparam int AW    = $clog2(NCH + 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_vld = 1'b0;
    logic [NCH*10-1:0] rx_frames = '0;
    logic              start = 1'b0, stop = 1'b0, clear = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [31:0]       rd_data;
    logic [9:0]        gen_frame;
    logic              running, synced;
    logic [NCH-1:0]    lost;

    prbs_err_checker #(.NCH(NCH), .ERR_W(ERR_W), .BIT_W(48)) dut (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .rx_frames(rx_frames),
        .start(start), .stop(stop), .clear(clear), .rd_addr(rd_addr),
        .rd_data(rd_data), .gen_frame(gen_frame), .running(running),
        .synced(synced), .lost(lost)
    );

    always #4 clk = ~clk;

    int     n_chk = 0, n_fail = 0;
    bit     done = 1'b0;

    logic [6:0] tx_st [NCH];
    logic [9:0] msk   [NCH];
    int         exp_err [NCH];
    bit         exp_lost [NCH];
    longint     exp_bits = 0;
    bit         exp_run = 0, exp_sync = 0;
    logic [6:0] gen_st = 7'h7F;
    logic [9:0] exp_gen = '0;

    // Model of one frame of x^7+x^6+1, oldest bit in bit 0: {state, frame}
    function automatic logic [16:0] mdl_step(input logic [6:0] s);
        logic [6:0] r = s;
        logic [9:0] f = '0;
        for (int i = 0; i < 10; i++) begin
            f[i] = r[6] ^ r[5];
            r = {r[5:0], f[i]};
        end
        return {r, f};
    endfunction

    function automatic int sat_add(input int a, input int b);
        return (a + b > EMAX) ? EMAX : a + b;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step(input bit vld, input bit st, input bit sp, input bit cl);
        logic [16:0] r;
        bit acc;
        @(negedge clk);
        frame_vld = vld; start = st; stop = sp; clear = cl;
        if (vld) begin
            for (int c = 0; c < NCH; c++) begin
                r = mdl_step(tx_st[c]);
                tx_st[c] = r[16:10];
                rx_frames[c*10 +: 10] = r[9:0] ^ msk[c];
            end
            r = mdl_step(gen_st);
            gen_st = r[16:10];
            exp_gen = r[9:0];
        end
        acc = vld && exp_run && !st && !sp && !cl;
        if (cl) begin
            exp_bits = 0; exp_sync = 0;
            for (int c = 0; c < NCH; c++) begin exp_err[c] = 0; exp_lost[c] = 0; end
        end
        if (acc) begin
            if (!exp_sync) exp_sync = 1;
            else begin
                exp_bits += 10;
                for (int c = 0; c < NCH; c++) begin
                    exp_err[c] = sat_add(exp_err[c], $countones(msk[c]));
                    if (msk[c] == 10'h3FF) exp_lost[c] = 1;
                end
            end
        end
        if (st) exp_sync = 0;
        if (sp) exp_run = 0; else if (st) exp_run = 1;
        @(negedge clk);
        frame_vld = 0; start = 0; stop = 0; clear = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic clean_masks();
        for (int c = 0; c < NCH; c++) msk[c] = '0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(0, v); chk(v == exp_bits[31:0], {tag, " R4 bit count"}, v, exp_bits);
        rd(1, v); chk(v == 0, {tag, " R9 bit count high"}, v, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(c + 2, v);
            chk(v == exp_err[c], {tag, " R3 error count"}, v, exp_err[c]);
            chk(lost[c] == exp_lost[c], {tag, " R6 lost flag"}, lost[c], exp_lost[c]);
        end
        rd(NCH + 2, v); chk(v == 0, {tag, " R9 unused address"}, v, 0);
        chk(running == exp_run, {tag, " R8 running"}, running, exp_run);
        chk(synced == exp_sync, {tag, " R2 synced"}, synced, exp_sync);
        chk(gen_frame == exp_gen, {tag, " R1 generator"}, gen_frame, exp_gen);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int c = 0; c < NCH; c++) begin
            tx_st[c] = 7'(($urandom % 127) + 1);
            msk[c] = '0; exp_err[c] = 0; exp_lost[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R10 reset");

        // Generator runs on the strobe even when idle; nothing counted
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0, 0);
            chk(gen_frame == exp_gen, "R1 generator frame", gen_frame, exp_gen);
        end
        check_all("R8 idle frames");

        // Start, then a sync frame
        step(0, 1, 0, 0);
        step(1, 0, 0, 0);
        check_all("R2 sync frame");

        // Random sparse errors
        for (int i = 0; i < 30; i++) begin
            for (int c = 0; c < NCH; c++)
                msk[c] = (($urandom % 4) == 0) ? 10'($urandom & $urandom & $urandom) : 10'h0;
            step(1, 0, 0, 0);
        end
        clean_masks();
        check_all("R3 random errors");

        // Saturation and lost flag on channel 1
        msk[1] = 10'h3FF;
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0);
        clean_masks();
        check_all("R5 saturation");
        chk(exp_err[1] == EMAX, "R5 model saturated", exp_err[1], EMAX);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        check_all("R6 lost sticky");

        // Stop: frames ignored
        step(0, 0, 1, 0);
        msk[0] = 10'h005;
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        clean_masks();
        check_all("R8 stopped");

        // Start together with a frame: frame ignored, then resync
        step(1, 1, 0, 0);
        check_all("R8 start with frame");
        step(1, 0, 0, 0);
        msk[2] = 10'h201;
        step(1, 0, 0, 0);
        clean_masks();
        check_all("R2 resync");

        // Clear together with a frame
        msk[3] = 10'h0F0;
        step(1, 0, 0, 1);
        clean_masks();
        check_all("R7 clear with frame");
        step(1, 0, 0, 0);
        msk[0] = 10'h3FF; msk[3] = 10'h011;
        step(1, 0, 0, 0);
        clean_masks();
        check_all("R7 after clear");

        // Start and stop together: stop wins
        step(0, 1, 1, 0);
        check_all("R8 start and stop");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule